// File: doc/BRIEF.md
# Multi-Mode Load-Store CPU Core

A small multi-cycle processor with a 16-bit datapath, four general purpose registers and a private 256-word by 16-bit memory. Every instruction is one 16-bit word. The core moves each fetch and each data access through a memory address register and a memory data register. It executes four operations: load, store, add and jump. Load, store and jump each choose between a direct 8-bit address, an address displaced by register 3, and an immediate form. The immediate form gives a sign-extended operand for a load and a jump relative to the instruction's own address.

While reset is held, a testbench or boot agent fills memory through a side port and sets the start address. When reset is released the core runs from that address. A read-only path on the same side port returns any memory word one cycle after its address is presented. Debug outputs show the program counter, the instruction register and all four registers.

Bit numbering follows the instruction format: format bit 0 is the most significant bit, vector bit 15.

Top module: `ls_core`

## Requirements
- R1: While `rst` is high, at every clock edge the core sets `dbg_pc` to `start_pc` and clears `dbg_ir` and all registers to zero.
- R2: Instruction format, with format bit 0 = vector bit 15:
  - opcode: vector bits 15:12 (0 load, 1 store, 2 add, 3 jump);
  - register select: bits 11:10;
  - displacement flag: bit 9;
  - immediate flag: bit 8;
  - 8-bit field: bits 7:0.

  Counting the first edge after an instruction starts as edge 1, the PC increments at edge 2 and the word appears in `dbg_ir` at edge 3. A memory load takes 6 cycles, a store 5 cycles and any other instruction 4 cycles.
- R3: Register 0 always reads zero. Writes to it, including a load into it, are discarded.
- R4: A direct load (bits 9 and 8 clear) writes `mem[field]` into the selected register at edge 6.
- R5: A store writes the selected register to the effective address at edge 5 and leaves all registers unchanged. The immediate flag is ignored on a store.
- R6: Add writes reg[bits 7:6] + reg[bits 5:4] (modulo 2^16) into reg[bits 11:10] at edge 4. With register 0 as a source it acts as a register move.
- R7: With bit 9 set, load, store and jump use the effective address field + R3[7:0], modulo 256.
- R8: A load with bit 8 set writes the field, sign-extended from bit 7 to 16 bits, into the register at edge 4.
- R9: A direct or displaced jump sets the PC to the effective address at edge 4. A jump with bit 8 set sets the PC to (own address + sign-extended field) modulo 256.
- R10: When bits 8 and 9 are both set on a load or jump, the immediate form is used and R3 is not applied.
- R11: Opcodes 4 to 15 change no register and no memory word. They take 4 cycles.
- R12: `ext_we` writes `ext_wdata` to `mem[ext_addr]` only while `rst` is high and is ignored otherwise. `ext_rdata` shows `mem[ext_addr]` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also enables side-port writes |
| start_pc | input | 8 | PC value loaded during reset |
| ext_we | input | 1 | Side-port memory write enable (used only in reset) |
| ext_addr | input | 8 | Side-port memory address |
| ext_wdata | input | 16 | Side-port write data |
| ext_rdata | output | 16 | Side-port registered read data |
| dbg_pc | output | 8 | Program counter |
| dbg_ir | output | 16 | Instruction register |
| dbg_regs | output | 64 | Registers, R0 in bits 15:0 up to R3 in bits 63:48 |

## Verification
The hardest cases to reach are the wrap-around corners:
- a displaced address whose field plus R3 passes 255;
- a relative jump that goes back across address 0;
- a load whose displacement and immediate flags are both set.

The stimulus reaches them with a program placed at 0xFE. It first loads R3 with 0x20, using an instruction that has both flags set. It then stores and loads through field 0xF0, so the effective address wraps to 0x10. It ends with a backward relative jump from 0x06 to 0xFE. A side-port write pulsed in the middle of this run shows that writes outside reset are ignored. A cycle-accurate behavioural model checks every step.

// File: rtl/ls_core_pkg.sv
package ls_core_pkg;
  typedef enum logic [2:0] {
    S_F0, S_F1, S_F2, S_EXE, S_MR1, S_MR2, S_MW
  } state_t;

  localparam logic [3:0] OP_LOAD  = 4'd0;
  localparam logic [3:0] OP_STORE = 4'd1;
  localparam logic [3:0] OP_ADD   = 4'd2;
  localparam logic [3:0] OP_JUMP  = 4'd3;
endpackage

// File: rtl/ls_ram.sv
module ls_ram #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/ls_regfile.sv
module ls_regfile #(
  parameter int NREG = 4,
  parameter int DW   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [$clog2(NREG)-1:0]  widx,
  input  logic [DW-1:0]            wdata,
  output logic [NREG*DW-1:0]       rall
);
  logic [DW-1:0] rf [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NREG; k++) rf[k] <= '0;
    end else if (we && widx != '0) begin
      rf[widx] <= wdata;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_pack
    assign rall[g*DW +: DW] = rf[g];
  end

  AST_R0_ZERO: assert property (@(posedge clk) disable iff (rst)
    rall[DW-1:0] == '0); // R3
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (we && widx != '0) |=> rall[$past(widx)*DW +: DW] == $past(wdata)); // R6
endmodule

// File: rtl/ls_core.sv
module ls_core
  import ls_core_pkg::*;
#(
  parameter int AW   = 8,
  parameter int DW   = 16,
  parameter int NREG = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [AW-1:0]       start_pc,
  input  logic                ext_we,
  input  logic [AW-1:0]       ext_addr,
  input  logic [DW-1:0]       ext_wdata,
  output logic [DW-1:0]       ext_rdata,
  output logic [AW-1:0]       dbg_pc,
  output logic [DW-1:0]       dbg_ir,
  output logic [NREG*DW-1:0]  dbg_regs
);
  localparam int RSW = $clog2(NREG);
  localparam int FW  = 8;

  state_t        state;
  logic [AW-1:0] pc, ma;
  logic [DW-1:0] md, ir;
  logic [DW-1:0] ram_rdata;
  logic [NREG*DW-1:0] rall;
  logic [DW-1:0] rv [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign rv[g] = rall[g*DW +: DW];
  end

  // instruction fields
  logic [3:0]     opc;
  logic [RSW-1:0] rsel, src_a, src_b;
  logic           dsp, imm;
  logic [FW-1:0]  fld;
  logic [DW-1:0]  sext, sum;
  logic [AW-1:0]  ea, rel;

  always_comb begin
    opc   = ir[15:12];
    rsel  = ir[11:10];
    dsp   = ir[9];
    imm   = ir[8];
    fld   = ir[7:0];
    src_a = ir[7:6];
    src_b = ir[5:4];
    sext  = {{(DW-FW){fld[FW-1]}}, fld};
    sum   = rv[src_a] + rv[src_b];
    ea    = AW'(fld) + (dsp ? rv[3][AW-1:0] : '0);
    rel   = pc - AW'(1) + sext[AW-1:0];
  end

  // register write port
  logic          rf_we;
  logic [RSW-1:0] rf_widx;
  logic [DW-1:0]  rf_wdata;

  always_comb begin
    rf_we    = 1'b0;
    rf_widx  = rsel;
    rf_wdata = sext;
    if (state == S_MR2) begin
      rf_we    = 1'b1;
      rf_wdata = ram_rdata;
    end else if (state == S_EXE) begin
      if (opc == OP_LOAD && imm) rf_we = 1'b1;
      if (opc == OP_ADD) begin
        rf_we    = 1'b1;
        rf_wdata = sum;
      end
    end
  end

  // memory port A: side port during reset, core otherwise
  logic          a_we;
  logic [AW-1:0] a_addr;
  logic [DW-1:0] a_wdata;

  always_comb begin
    a_we    = rst ? ext_we    : (state == S_MW);
    a_addr  = rst ? ext_addr  : ma;
    a_wdata = rst ? ext_wdata : md;
  end

  ls_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(ram_rdata), .b_addr(ext_addr), .b_rdata(ext_rdata)
  );

  ls_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .widx(rf_widx),
    .wdata(rf_wdata), .rall(rall)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_F0;
      pc    <= start_pc;
      ma    <= '0;
      md    <= '0;
      ir    <= '0;
    end else begin
      case (state)
        S_F0: begin
          ma    <= pc;
          state <= S_F1;
        end
        S_F1: begin
          pc    <= pc + AW'(1);
          state <= S_F2;
        end
        S_F2: begin
          md    <= ram_rdata;
          ir    <= ram_rdata;
          state <= S_EXE;
        end
        S_EXE: begin
          state <= S_F0;
          case (opc)
            OP_LOAD: if (!imm) begin
              ma    <= ea;
              state <= S_MR1;
            end
            OP_STORE: begin
              ma    <= ea;
              md    <= rv[rsel];
              state <= S_MW;
            end
            OP_JUMP: pc <= imm ? rel : ea;
            default: ;
          endcase
        end
        S_MR1: state <= S_MR2;
        S_MR2: begin
          md    <= ram_rdata;
          state <= S_F0;
        end
        S_MW:    state <= S_F0;
        default: state <= S_F0;
      endcase
    end
  end

  assign dbg_pc   = pc;
  assign dbg_ir   = ir;
  assign dbg_regs = rall;

  AST_FETCH_SEQ: assert property (@(posedge clk) disable iff (rst)
    (state == S_F0) |=> (state == S_F1)); // R2
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (state == S_F1) |=> (pc == $past(pc) + AW'(1))); // R2
  AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state != S_F2) |=> $stable(ir)); // R2
  AST_STORE_KEEPS_REGS: assert property (@(posedge clk) disable iff (rst)
    (state == S_MW) |=> $stable(rall)); // R5
  AST_IMM_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    (state == S_EXE && opc == OP_LOAD && imm && rsel != '0)
      |=> (rall[$past(rsel)*DW +: DW] == {{(DW-FW){$past(ir[7])}}, $past(ir[7:0])})); // R8
  AST_REL_TARGET: assert property (@(posedge clk) disable iff (rst)
    (state == S_EXE && opc == OP_JUMP && imm)
      |=> (pc == $past(ma) + {{(AW-FW){$past(ir[7])}}, $past(ir[7:0])})); // R9
endmodule

// File: tb/sim_ls_core.sv
module sim_ls_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  start_pc = 8'd0;
  logic        ext_we = 1'b0;
  logic [7:0]  ext_addr = 8'd0;
  logic [15:0] ext_wdata = 16'd0;
  logic [15:0] ext_rdata;
  logic [7:0]  dbg_pc;
  logic [15:0] dbg_ir;
  logic [63:0] dbg_regs;

  always #5 clk = ~clk;

  ls_core u0 (
    .clk(clk), .rst(rst), .start_pc(start_pc), .ext_we(ext_we),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
    .dbg_pc(dbg_pc), .dbg_ir(dbg_ir), .dbg_regs(dbg_regs)
  );

  int compared = 0;
  int mismatched = 0;
  bit running = 0;

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [15:0] m_mem [256];
  logic [15:0] m_r [4];
  logic [7:0]  m_pc, fa, m_ea;
  logic [15:0] m_ir, st_val;
  logic [1:0]  ld_idx;
  int          step = 0;
  bit          pend_store;
  string       cur_tag = "R1";

  function automatic logic [15:0] sx(input logic [7:0] f);
    return {{8{f[7]}}, f};
  endfunction

  task automatic wreg(input logic [1:0] i, input logic [15:0] v);
    if (i != 2'd0) m_r[i] = v;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      step = 0; m_pc = start_pc; m_ir = 16'd0;
      for (int k = 0; k < 4; k++) m_r[k] = 16'd0;
    end else begin
      case (step)
        0: step = 1;
        1: begin fa = m_pc; m_pc = m_pc + 8'd1; step = 2; end
        2: begin m_ir = m_mem[fa]; step = 3; end
        3: begin
          logic [3:0] op;
          logic [1:0] rs;
          logic d, i;
          logic [7:0] f;
          op = m_ir[15:12]; rs = m_ir[11:10]; d = m_ir[9]; i = m_ir[8]; f = m_ir[7:0];
          m_ea = f + (d ? m_r[3][7:0] : 8'd0);
          step = 0;
          case (op)
            4'd0: begin
              if (i) begin
                cur_tag = d ? "R10" : (rs == 0 ? "R3" : "R8");
                wreg(rs, sx(f));
              end else begin
                cur_tag = rs == 0 ? "R3" : (d ? "R7" : "R4");
                ld_idx = rs; pend_store = 0; step = 4;
              end
            end
            4'd1: begin
              cur_tag = "R5"; st_val = m_r[rs]; pend_store = 1; step = 4;
            end
            4'd2: begin
              cur_tag = "R6"; wreg(rs, m_r[m_ir[7:6]] + m_r[m_ir[5:4]]);
            end
            4'd3: begin
              cur_tag = "R9";
              m_pc = i ? (fa + f) : m_ea;
            end
            default: cur_tag = "R11";
          endcase
        end
        4: if (pend_store) begin m_mem[m_ea] = st_val; step = 0; end
           else step = 5;
        5: begin wreg(ld_idx, m_mem[m_ea]); step = 0; end
        default: step = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (running) begin
      chk(cur_tag == "R9" ? "R9" : "R2", "pc", {8'd0, dbg_pc}, {8'd0, m_pc});
      chk("R2", "ir", dbg_ir, m_ir);
      for (int k = 0; k < 4; k++)
        chk(k == 0 ? "R3" : cur_tag, "reg", dbg_regs[k*16 +: 16], m_r[k]);
    end
  end

  function automatic logic [15:0] enc(input logic [3:0] op, input logic [1:0] r,
                                      input logic d, input logic i, input logic [7:0] f);
    return {op, r, d, i, f};
  endfunction

  function automatic logic [15:0] add3(input logic [1:0] rd, input logic [1:0] ra,
                                       input logic [1:0] rb);
    return {4'h2, rd, 2'b00, ra, rb, 4'h0};
  endfunction

  task automatic poke(input logic [7:0] a, input logic [15:0] v);
    @(negedge clk);
    ext_we = 1'b1; ext_addr = a; ext_wdata = v;
    m_mem[a] = v;
  endtask

  task automatic clear_mem();
    rst = 1'b1;
    for (int a = 0; a < 256; a++) poke(8'(a), 16'd0);
  endtask

  task automatic run_prog(input logic [7:0] s, input int ncyc, input int poke_at);
    @(negedge clk);
    ext_we = 1'b0;
    start_pc = s;
    repeat (2) @(negedge clk);
    chk("R1", "reset pc", {8'd0, dbg_pc}, {8'd0, s});
    chk("R1", "reset ir", dbg_ir, 16'd0);
    chk("R1", "reset regs", dbg_regs[15:0] | dbg_regs[31:16] | dbg_regs[47:32] | dbg_regs[63:48], 16'd0);
    running = 1; rst = 1'b0;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      if (c == poke_at) begin
        ext_we = 1'b1; ext_addr = 8'h40; ext_wdata = 16'hBEEF;
      end else begin
        ext_we = 1'b0;
      end
    end
    running = 0; rst = 1'b1; ext_we = 1'b0;
    for (int a = 0; a < 256; a++) begin
      ext_addr = 8'(a);
      @(negedge clk);
      chk("R12", "readback", ext_rdata, m_mem[a]);
    end
  endtask

  initial begin
    #2000000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // program A: direct load, add, store, direct jump loop
    clear_mem();
    poke(8'd3, 16'd2); poke(8'd4, 16'd1);
    poke(8'd10, enc(4'd0, 2'd1, 0, 0, 8'd3));
    poke(8'd11, enc(4'd0, 2'd2, 0, 0, 8'd4));
    poke(8'd12, add3(2'd1, 2'd1, 2'd2));
    poke(8'd13, enc(4'd1, 2'd1, 0, 0, 8'd5));
    poke(8'd14, enc(4'd3, 2'd0, 0, 0, 8'd12));
    run_prog(8'd10, 80, -1);

    // program B: displacement addressing and load into R0
    clear_mem();
    poke(8'd1, 16'd2); poke(8'd2, 16'd6); poke(8'd3, 16'd11);
    poke(8'd4, 16'd14); poke(8'd5, 16'd7);
    poke(8'd10, enc(4'd0, 2'd3, 0, 0, 8'd1));
    poke(8'd11, enc(4'd0, 2'd2, 1, 0, 8'd2));
    poke(8'd12, add3(2'd2, 2'd2, 2'd2));
    poke(8'd13, enc(4'd1, 2'd2, 0, 0, 8'd6));
    poke(8'd14, enc(4'd0, 2'd0, 0, 0, 8'd6));
    poke(8'd15, enc(4'd1, 2'd2, 1, 0, 8'd6));
    poke(8'd16, enc(4'd3, 2'd0, 1, 0, 8'd10));
    run_prog(8'd10, 90, -1);

    // program C: immediate load (negative) and relative jump
    clear_mem();
    poke(8'd10, enc(4'd0, 2'd1, 0, 1, 8'd3));
    poke(8'd11, enc(4'd1, 2'd1, 0, 0, 8'd4));
    poke(8'd12, enc(4'd0, 2'd2, 0, 1, 8'hFC));
    poke(8'd13, add3(2'd2, 2'd2, 2'd1));
    poke(8'd14, enc(4'd1, 2'd2, 0, 0, 8'd5));
    poke(8'd15, enc(4'd3, 2'd0, 0, 1, 8'hFE));
    run_prog(8'd10, 60, -1);
    chk("R5", "mem[4] after store of R1=3", m_mem[4], 16'h0003);

    // program D: wrap corners, priority, nop, ignored side write
    clear_mem();
    poke(8'hFE, enc(4'd0, 2'd3, 1, 1, 8'h20));   // R10 both flags
    poke(8'hFF, 16'h7ABC);                       // R11 unused opcode
    poke(8'h00, enc(4'd1, 2'd3, 1, 1, 8'hF0));   // R5/R7 store, imm ignored, wraps to 0x10
    poke(8'h01, add3(2'd1, 2'd3, 2'd0));         // R6 move
    poke(8'h02, enc(4'd0, 2'd2, 1, 0, 8'hF0));   // R7 load via wrap
    poke(8'h03, enc(4'd0, 2'd0, 0, 1, 8'h05));   // R3 immediate to R0
    poke(8'h04, enc(4'd0, 2'd1, 0, 1, 8'h80));   // R8 -128
    poke(8'h05, enc(4'd0, 2'd0, 0, 0, 8'h10));   // R3 memory load to R0
    poke(8'h06, enc(4'd3, 2'd0, 1, 1, 8'hF8));   // R9/R10 back to 0xFE
    run_prog(8'hFE, 100, 30);
    chk("R7", "mem[0x10] wrapped store", m_mem[8'h10], 16'h0020);
    chk("R12", "side write outside reset ignored (model)", m_mem[8'h40], 16'h0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule